// File: doc/BRIEF.md
# Cell Balancing Control Register

This block is the host-facing control register of a battery-monitor balancing engine, together with the sequencing logic around it. The host writes one 8-bit word that carries a live pause flag, a fault-stop policy, an over-temperature-during-balance detect enable, a two-bit completion action, a self-clearing start bit and an auto/manual mode select. Only the start bit makes the configuration take effect. Writing it with a 1 copies the policy fields into shadow registers, and those shadows drive the balancing engine until the next start.

While balancing is active, the block gates the engine's enable with the live pause bit. A thermal shutdown always stops balancing. An unmasked fault stops it only when the captured fault-stop policy says so. When the timer logic signals that balancing is complete, the block drops the active state and raises a single-cycle sleep or shutdown request, chosen by the captured completion action. A stop caused by a fault or by thermal shutdown raises no request.

Top module: `cbal_ctrl_top`

## Requirements
- R1: After a synchronous reset, the read-back word, balancing-active, balance-enable, pause, auto, over-temperature-detect, sleep-request and shutdown-request outputs are all 0.
- R2: The word has this layout: bit 7 is reserved, bit 6 is pause, bit 5 is fault-stop enable, bit 4 is over-temperature detect enable, bits 3:2 are the completion action, bit 1 is go and bit 0 is auto mode. Every write updates the live word. Bits 7 and 1 always read back as 0, and every other bit reads back as last written.
- R3: A write with bit 1 set copies bits 5, 4, 3:2 and 0 of that write into the shadow configuration. After that clock edge, balancing-active is 1, and the auto and over-temperature-detect outputs show the captured bits 0 and 4.
- R4: A write with bit 1 clear leaves the shadow configuration unchanged. The auto and over-temperature-detect outputs and the fault-stop behaviour keep their captured values.
- R5: The pause output follows live bit 6 on the edge after the write. Balance-enable equals balancing-active AND NOT pause. Pausing does not clear balancing-active.
- R6: If the captured fault-stop enable is 1, an unmasked fault while balancing is active clears balancing-active on the next edge. If it is 0, a fault has no effect.
- R7: A thermal shutdown while balancing is active clears balancing-active on the next edge, whatever the fault-stop policy.
- R8: A completion indication while active, with no stop condition present, clears balancing-active. On the same edge it raises a request that lasts one cycle: sleep for action 01, shutdown for action 10, and nothing for 00 or 11.
- R9: No request is raised if balancing was stopped by a fault or by thermal shutdown. This includes a completion that arrives in the same cycle as a stop, and a completion that arrives while balancing is inactive.
- R10: A go write while balancing is already active recaptures the configuration, and the new completion action then governs the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back word |
| fault_i | input | 1 | Unmasked fault present |
| tsd_i | input | 1 | Thermal shutdown present |
| done_i | input | 1 | Balancing complete, from the timer logic |
| bal_active_o | output | 1 | Balancing session active |
| bal_en_o | output | 1 | Balancing enable to the engine |
| pause_o | output | 1 | Live pause to the engine |
| auto_mode_o | output | 1 | Captured auto (1) or manual (0) mode |
| otdet_en_o | output | 1 | Captured over-temperature detect enable |
| sleep_req_o | output | 1 | One-cycle sleep request |
| shdn_req_o | output | 1 | One-cycle shutdown request |

## Verification
The assertions do not assume anything about how the host sequences its writes. They do assume that the fault, thermal and completion inputs are synchronous to the clock and valid at each edge. The checks that a stop clears the active state exclude the cycle of a go write, because go takes priority over a stop. The bench changes every input only on the falling edge. It pulses each flag for exactly one cycle, so each stop or completion event lands on a single known edge.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    localparam int REG_W     = 8;
    localparam int ACT_W     = 2;
    localparam int RSVD_BIT  = 7;
    localparam int PAUSE_BIT = 6;
    localparam int FSTOP_BIT = 5;
    localparam int OTDET_BIT = 4;
    localparam int ACT_HI    = 3;
    localparam int ACT_LO    = 2;
    localparam int GO_BIT    = 1;
    localparam int AUTO_BIT  = 0;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE  = 2'b00,
        ACT_SLEEP = 2'b01,
        ACT_SHDN  = 2'b10,
        ACT_RSVD  = 2'b11
    } done_act_e;

    typedef struct packed {
        logic      pause;
        logic      fstop_en;
        logic      otdet_en;
        done_act_e act;
        logic      auto_mode;
    } live_cfg_t;

    typedef struct packed {
        logic      fstop_en;
        logic      otdet_en;
        done_act_e act;
        logic      auto_mode;
    } shadow_cfg_t;

    function automatic live_cfg_t unpack_word(input logic [REG_W-1:0] d);
        live_cfg_t c;
        c.pause     = d[PAUSE_BIT];
        c.fstop_en  = d[FSTOP_BIT];
        c.otdet_en  = d[OTDET_BIT];
        c.act       = done_act_e'(d[ACT_HI:ACT_LO]);
        c.auto_mode = d[AUTO_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input live_cfg_t c);
        logic [REG_W-1:0] w;
        w                = '0;
        w[PAUSE_BIT]     = c.pause;
        w[FSTOP_BIT]     = c.fstop_en;
        w[OTDET_BIT]     = c.otdet_en;
        w[ACT_HI:ACT_LO] = c.act;
        w[AUTO_BIT]      = c.auto_mode;
        return w;
    endfunction

    function automatic shadow_cfg_t to_shadow(input live_cfg_t c);
        shadow_cfg_t s;
        s.fstop_en  = c.fstop_en;
        s.otdet_en  = c.otdet_en;
        s.act       = c.act;
        s.auto_mode = c.auto_mode;
        return s;
    endfunction

    function automatic logic wants_sleep(input done_act_e a);
        return a == ACT_SLEEP;
    endfunction

    function automatic logic wants_shdn(input done_act_e a);
        return a == ACT_SHDN;
    endfunction

endpackage

// File: rtl/cbal_regfile.sv
module cbal_regfile
    import cbal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output live_cfg_t        live_cfg,
    output live_cfg_t        wr_cfg,
    output logic             go,
    output logic [REG_W-1:0] rd_data
);

    logic unused_rsvd;
    assign unused_rsvd = wr_data[RSVD_BIT];

    assign wr_cfg = unpack_word(wr_data);
    assign go     = wr_en & wr_data[GO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_cfg <= '0;
        end else if (wr_en) begin
            live_cfg <= wr_cfg;
        end
    end

    assign rd_data = pack_word(live_cfg);

    AST_RD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[PAUSE_BIT] == $past(wr_data[PAUSE_BIT])
                   && rd_data[AUTO_BIT] == $past(wr_data[AUTO_BIT]))); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/cbal_shadow.sv
module cbal_shadow
    import cbal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  live_cfg_t   wr_cfg,
    output shadow_cfg_t shd_cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg <= '0;
        end else if (go) begin
            shd_cfg <= to_shadow(wr_cfg);
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(shd_cfg)); // R4

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        go |=> (shd_cfg.auto_mode == $past(wr_cfg.auto_mode)
                && shd_cfg.act == $past(wr_cfg.act))); // R3

endmodule

// File: rtl/cbal_seq.sv
module cbal_seq
    import cbal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  shadow_cfg_t shd_cfg,
    input  logic        pause,
    input  logic        fault,
    input  logic        tsd,
    input  logic        done,
    output logic        active,
    output logic        bal_en,
    output logic        sleep_req,
    output logic        shdn_req
);

    logic stop_now;
    logic finish_now;

    assign stop_now   = active & (tsd | (shd_cfg.fstop_en & fault));
    assign finish_now = active & done & ~stop_now & ~go;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
        end else if (stop_now || (active && done)) begin
            active <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_req <= 1'b0;
            shdn_req  <= 1'b0;
        end else begin
            sleep_req <= finish_now & wants_sleep(shd_cfg.act);
            shdn_req  <= finish_now & wants_shdn(shd_cfg.act);
        end
    end

    assign bal_en = active & ~pause;

    AST_GO_STARTS: assert property (@(posedge clk) disable iff (rst)
        go |=> active); // R3

    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (rst)
        (active && fault && shd_cfg.fstop_en && !go) |=> !active); // R6

    AST_TSD_STOP: assert property (@(posedge clk) disable iff (rst)
        (active && tsd && !go) |=> !active); // R7

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sleep_req && shdn_req)); // R8

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (sleep_req || shdn_req) |=> !(sleep_req || shdn_req)); // R8

    AST_REQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (sleep_req || shdn_req) |-> $past(active && done && !tsd)); // R9

    AST_PAUSE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (active && !go && !tsd && !fault && !done) |=> active); // R5

endmodule

// File: rtl/cbal_ctrl_top.sv
module cbal_ctrl_top
    import cbal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             fault_i,
    input  logic             tsd_i,
    input  logic             done_i,
    output logic             bal_active_o,
    output logic             bal_en_o,
    output logic             pause_o,
    output logic             auto_mode_o,
    output logic             otdet_en_o,
    output logic             sleep_req_o,
    output logic             shdn_req_o
);

    live_cfg_t   live_cfg;
    live_cfg_t   wr_cfg;
    shadow_cfg_t shd_cfg;
    logic        go;

    cbal_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .live_cfg (live_cfg),
        .wr_cfg   (wr_cfg),
        .go       (go),
        .rd_data  (rd_data)
    );

    cbal_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .wr_cfg  (wr_cfg),
        .shd_cfg (shd_cfg)
    );

    cbal_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .shd_cfg   (shd_cfg),
        .pause     (live_cfg.pause),
        .fault     (fault_i),
        .tsd       (tsd_i),
        .done      (done_i),
        .active    (bal_active_o),
        .bal_en    (bal_en_o),
        .sleep_req (sleep_req_o),
        .shdn_req  (shdn_req_o)
    );

    assign pause_o     = live_cfg.pause;
    assign auto_mode_o = shd_cfg.auto_mode;
    assign otdet_en_o  = shd_cfg.otdet_en;

    AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        bal_en_o |-> (bal_active_o && !pause_o)); // R5

endmodule

// File: tb/tb_cbal_ctrl_top.sv
module tb_cbal_ctrl_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       fault_i, tsd_i, done_i;
    logic       bal_active_o, bal_en_o, pause_o, auto_mode_o, otdet_en_o;
    logic       sleep_req_o, shdn_req_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbal_ctrl_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fault_i(fault_i), .tsd_i(tsd_i), .done_i(done_i),
        .bal_active_o(bal_active_o), .bal_en_o(bal_en_o), .pause_o(pause_o),
        .auto_mode_o(auto_mode_o), .otdet_en_o(otdet_en_o),
        .sleep_req_o(sleep_req_o), .shdn_req_o(shdn_req_o)
    );

    // word: {rsvd, pause, fstop, otdet, act[1:0], go, auto}
    function automatic logic [7:0] mk(input logic p, input logic fs, input logic ot,
                                      input logic [1:0] a, input logic g, input logic au);
        return {1'b0, p, fs, ot, a, g, au};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic f, input logic t, input logic d);
        fault_i = f; tsd_i = t; done_i = d;
        @(negedge clk);
        fault_i = 1'b0; tsd_i = 1'b0; done_i = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        fault_i = 1'b0; tsd_i = 1'b0; done_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 outputs", {bal_active_o, bal_en_o, pause_o, auto_mode_o,
                           otdet_en_o, sleep_req_o, shdn_req_o}, 8'h00);
    endtask

    task automatic t_readback;
        wr(8'hFF);
        chk("R2 reserved and go read 0", rd_data, 8'h7D);
        chk("R2 pause follows live", pause_o, 1'b1);
        wr(8'h29);
        chk("R2 pattern", rd_data, 8'h29);
        wr(8'h00);
        // clear the session started by the 0xFF write (go bit set)
        pulse(1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_go_capture;
        wr(mk(0, 0, 1, 2'b00, 1, 1));
        chk("R3 active after go", bal_active_o, 1'b1);
        chk("R3 auto captured", auto_mode_o, 1'b1);
        chk("R3 otdet captured", otdet_en_o, 1'b1);
        chk("R3 enable", bal_en_o, 1'b1);
    endtask

    task automatic t_no_effect;
        wr(mk(0, 1, 1, 2'b00, 1, 1));
        wr(mk(0, 0, 0, 2'b01, 0, 0));
        chk("R4 rd shows live", rd_data, 8'h04);
        chk("R4 auto kept", auto_mode_o, 1'b1);
        chk("R4 otdet kept", otdet_en_o, 1'b1);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R4 captured fault-stop still applies", bal_active_o, 1'b0);
    endtask

    task automatic t_pause;
        wr(mk(0, 0, 0, 2'b00, 1, 0));
        wr(mk(1, 0, 0, 2'b00, 0, 0));
        chk("R5 pause out", pause_o, 1'b1);
        chk("R5 enable gated", bal_en_o, 1'b0);
        chk("R5 active kept", bal_active_o, 1'b1);
        wr(mk(0, 0, 0, 2'b00, 0, 0));
        chk("R5 resume", bal_en_o, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_fault_policy;
        wr(mk(0, 0, 0, 2'b00, 1, 0));
        pulse(1'b1, 1'b0, 1'b0);
        chk("R6 fault ignored with policy 0", bal_active_o, 1'b1);
        wr(mk(0, 1, 0, 2'b00, 1, 0));
        pulse(1'b1, 1'b0, 1'b0);
        chk("R6 fault stops with policy 1", bal_active_o, 1'b0);
    endtask

    task automatic t_thermal;
        wr(mk(0, 0, 0, 2'b01, 1, 0));
        pulse(1'b0, 1'b1, 1'b0);
        chk("R7 thermal stop", bal_active_o, 1'b0);
        chk("R9 no request on thermal stop", {sleep_req_o, shdn_req_o}, 8'h00);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R9 done while inactive", {sleep_req_o, shdn_req_o}, 8'h00);
    endtask

    task automatic t_completion;
        for (int c = 0; c < 4; c++) begin
            wr(mk(0, 0, 0, c[1:0], 1, 0));
            pulse(1'b0, 1'b0, 1'b1);
            chk("R8 active cleared", bal_active_o, 1'b0);
            chk("R8 sleep by code", sleep_req_o, (c == 1) ? 1'b1 : 1'b0);
            chk("R8 shutdown by code", shdn_req_o, (c == 2) ? 1'b1 : 1'b0);
            @(negedge clk);
            chk("R8 single cycle", {sleep_req_o, shdn_req_o}, 8'h00);
        end
    endtask

    task automatic t_stop_and_done;
        wr(mk(0, 1, 0, 2'b01, 1, 0));
        pulse(1'b1, 1'b0, 1'b1);
        chk("R9 fault with done: stopped", bal_active_o, 1'b0);
        chk("R9 fault with done: no request", {sleep_req_o, shdn_req_o}, 8'h00);
    endtask

    task automatic t_rego;
        wr(mk(0, 0, 0, 2'b10, 1, 0));
        wr(mk(0, 0, 0, 2'b01, 1, 1));
        chk("R10 still active", bal_active_o, 1'b1);
        chk("R10 auto recaptured", auto_mode_o, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R10 new action sleep", sleep_req_o, 1'b1);
        chk("R10 old action dropped", shdn_req_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_readback;
        t_go_capture;
        t_no_effect;
        t_pause;
        t_fault_policy;
        t_thermal;
        t_completion;
        t_stop_and_done;
        t_rego;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule